// File: doc/BRIEF.md
# Saturating Packed Word-by-Half Multiply-Accumulate

This block is a two-stage packed datapath that, in every 32-bit lane, multiplies a signed 32-bit word by a signed 16-bit half taken from a second operand. From the 48-bit product it keeps the upper 32 bits, either as they are or doubled (fractional Q31 by Q15 scaling), truncated or rounded. That value is added to the matching signed 32-bit lane of an accumulator operand and the sum is clamped to the signed 32-bit range.

A caller presents the accumulator, word and half operands together with the mode bits and a valid strobe. Two clock edges later the new packed accumulator comes out with a valid strobe and a per-operation overflow bit. The block also keeps a sticky overflow flag that collects every overflow event until it is cleared explicitly. The datapath width is a parameter: 32 bits gives one lane and 64 bits gives two independent lanes.

Top module: `simd_msw_mac`

## Requirements
- R1: Lane i occupies bits 32i+31:32i of every packed operand. With `use_top`=0 the half is bits 15:0 of the lane in `half_src`. With `use_top`=1 it is bits 31:16.
- R2: Plain mode (`dbl_mode`=0, `rnd_mode`=0): the addend is bits 47:16 of the signed 48-bit product.
- R3: Plain rounded mode (`dbl_mode`=0, `rnd_mode`=1): the addend is bits 32:1 of (product bits 47:15 + 1).
- R4: Doubled mode (`dbl_mode`=1, `rnd_mode`=0): the addend is product bits 46:15.
- R5: Doubled rounded mode (`dbl_mode`=1, `rnd_mode`=1): product bits 47:14 are incremented by one, and bits 46:15 of the result form the addend.
- R6: In doubled mode, a word of 0x80000000 with a half of 0x8000 forces the addend to 0x7FFFFFFF and raises overflow. The add still takes place with that addend and may saturate again.
- R7: A lane sum above 0x7FFFFFFF becomes 0x7FFFFFFF and a sum below -2^31 becomes 0x80000000. Either clamp raises overflow.
- R8: Lanes are computed independently. `ov_out` is the OR of every lane's overflow events from both saturation points.
- R9: A valid operation presented at a rising edge appears on `acc_out` with `out_valid` and `ov_out` after the second following rising edge. Operations may be issued every cycle. When no result is valid, `acc_out` holds its last value and `ov_out` is 0.
- R10: `ov_sticky` rises with any `ov_out` and stays high until `ov_clr`. An overflow event in the same cycle as the clear still leaves it set.
- R11: After reset, `out_valid`, `ov_out` and `ov_sticky` are 0 and `acc_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| acc_in | input | XLEN | Packed signed accumulator lanes |
| word_src | input | XLEN | Packed signed 32-bit multiplicands |
| half_src | input | XLEN | Packed lanes supplying the 16-bit multiplier |
| use_top | input | 1 | Select the upper half of each lane (1) or the lower half (0) |
| dbl_mode | input | 1 | Double the product before the upper 32 bits are taken |
| rnd_mode | input | 1 | Round the product at the highest discarded bit |
| ov_clr | input | 1 | Clear the sticky overflow flag |
| out_valid | output | 1 | Result strobe |
| acc_out | output | XLEN | Packed saturated accumulator result |
| ov_out | output | 1 | Overflow raised by the operation on `acc_out` |
| ov_sticky | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is the doubled-mode corner. Here the forced 0x7FFFFFFF addend meets a positive accumulator and saturates a second time, while the other lane stays in range and must not be disturbed. Random operands almost never produce this case. Directed operations therefore set the word to 0x80000000 and the selected half to 0x8000 in one lane only, and pair them with positive and negative accumulators. The random phase also draws those two extreme values with high probability, so the corner meets every rounding and half-select setting.

// File: rtl/msw_mac_pkg.sv
package msw_mac_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned PROD_W = WORD_W + HALF_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [PROD_W-1:0] prod_t;

    localparam word_t WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};
    localparam half_t HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};

endpackage

// File: rtl/msw_lane_mul.sv
module msw_lane_mul
    import msw_mac_pkg::*;
(
    input  word_t word_i,
    input  half_t half_i,
    input  logic  dbl_i,
    input  logic  rnd_i,
    output word_t addend_o,
    output logic  corner_o
);

    prod_t         wide_word;
    prod_t         wide_half;
    prod_t         product;
    logic [WORD_W:0]   plain_rnd;
    logic [WORD_W+1:0] dbl_rnd;

    always_comb begin
        wide_word = {{HALF_W{word_i[WORD_W-1]}}, word_i};
        wide_half = {{WORD_W{half_i[HALF_W-1]}}, half_i};
        product   = prod_t'($signed(wide_word) * $signed(wide_half));

        // Rounding adds one at the highest discarded position.
        plain_rnd = product[PROD_W-1:HALF_W-1] + {{WORD_W{1'b0}}, 1'b1};
        dbl_rnd   = product[PROD_W-1:HALF_W-2] + {{(WORD_W+1){1'b0}}, 1'b1};

        corner_o = dbl_i && (word_i == WORD_MIN) && (half_i == HALF_MIN);

        if (corner_o) begin
            addend_o = WORD_MAX;
        end else if (dbl_i) begin
            addend_o = rnd_i ? dbl_rnd[WORD_W:1] : product[PROD_W-2:HALF_W-1];
        end else begin
            addend_o = rnd_i ? plain_rnd[WORD_W:1] : product[PROD_W-1:HALF_W];
        end
    end

endmodule

// File: rtl/msw_lane_sat.sv
module msw_lane_sat
    import msw_mac_pkg::*;
(
    input  word_t acc_i,
    input  word_t addend_i,
    output word_t sum_o,
    output logic  sat_o
);

    logic [WORD_W:0] wide_sum;

    always_comb begin
        wide_sum = {acc_i[WORD_W-1], acc_i} + {addend_i[WORD_W-1], addend_i};
        // The top two bits disagree exactly when the true sum leaves the range.
        sat_o = wide_sum[WORD_W] ^ wide_sum[WORD_W-1];
        if (!sat_o) begin
            sum_o = wide_sum[WORD_W-1:0];
        end else if (wide_sum[WORD_W]) begin
            sum_o = WORD_MIN;
        end else begin
            sum_o = WORD_MAX;
        end
    end

endmodule

// File: rtl/simd_msw_mac.sv
module simd_msw_mac
    import msw_mac_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] acc_in,
    input  logic [XLEN-1:0] word_src,
    input  logic [XLEN-1:0] half_src,
    input  logic            use_top,
    input  logic            dbl_mode,
    input  logic            rnd_mode,
    input  logic            ov_clr,
    output logic            out_valid,
    output logic [XLEN-1:0] acc_out,
    output logic            ov_out,
    output logic            ov_sticky
);

    localparam int unsigned LANES = XLEN / WORD_W;

    typedef struct packed {
        logic             vld;
        logic [XLEN-1:0]  acc;
        logic [XLEN-1:0]  add;
        logic [LANES-1:0] corner;
    } mul_stage_t;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            ov;
        logic            sticky;
    } sat_stage_t;

    mul_stage_t mul_d, mul_q;
    sat_stage_t sat_d, sat_q;

    logic [XLEN-1:0]  addend_w;
    logic [LANES-1:0] corner_w;
    logic [XLEN-1:0]  sum_w;
    logic [LANES-1:0] sat_w;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        word_t lane_word;
        half_t lane_half;

        always_comb begin
            lane_word = word_src[ln*WORD_W +: WORD_W];
            lane_half = use_top ? half_src[ln*WORD_W + HALF_W +: HALF_W]
                                : half_src[ln*WORD_W +: HALF_W];
        end

        msw_lane_mul u_mul (
            .word_i   (lane_word),
            .half_i   (lane_half),
            .dbl_i    (dbl_mode),
            .rnd_i    (rnd_mode),
            .addend_o (addend_w[ln*WORD_W +: WORD_W]),
            .corner_o (corner_w[ln])
        );

        msw_lane_sat u_sat (
            .acc_i    (mul_q.acc[ln*WORD_W +: WORD_W]),
            .addend_i (mul_q.add[ln*WORD_W +: WORD_W]),
            .sum_o    (sum_w[ln*WORD_W +: WORD_W]),
            .sat_o    (sat_w[ln])
        );
    end

    always_comb begin
        mul_d     = mul_q;
        mul_d.vld = in_valid;
        if (in_valid) begin
            mul_d.acc    = acc_in;
            mul_d.add    = addend_w;
            mul_d.corner = corner_w;
        end

        sat_d     = sat_q;
        sat_d.vld = mul_q.vld;
        sat_d.ov  = 1'b0;
        if (mul_q.vld) begin
            sat_d.res = sum_w;
            sat_d.ov  = (|sat_w) | (|mul_q.corner);
        end
        sat_d.sticky = (sat_q.sticky & ~ov_clr) | sat_d.ov;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= '0;
            sat_q <= '0;
        end else begin
            mul_q <= mul_d;
            sat_q <= sat_d;
        end
    end

    assign out_valid = sat_q.vld;
    assign acc_out   = sat_q.res;
    assign ov_out    = sat_q.ov;
    assign ov_sticky = sat_q.sticky;

endmodule

// File: rtl/msw_mac_chk.sv
module msw_mac_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            ov_clr,
    input logic            out_valid,
    input logic [XLEN-1:0] acc_out,
    input logic            ov_out,
    input logic            ov_sticky
);

    // R9
    latency_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R9
    latency_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(acc_out) && !ov_out));

    // R10
    sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_out |-> ov_sticky);

    // R10
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_sticky && !ov_clr) |=> ov_sticky);

    // R10
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_clr |=> (ov_sticky == ov_out));

endmodule

bind simd_msw_mac msw_mac_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ov_clr    (ov_clr),
    .out_valid (out_valid),
    .acc_out   (acc_out),
    .ov_out    (ov_out),
    .ov_sticky (ov_sticky)
);

// File: tb/simd_msw_mac_test.sv
module simd_msw_mac_test;

    localparam int unsigned XLEN  = 64;
    localparam int unsigned LANES = XLEN / 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] acc_in = '0;
    logic [XLEN-1:0] word_src = '0;
    logic [XLEN-1:0] half_src = '0;
    logic            use_top = 1'b0;
    logic            dbl_mode = 1'b0;
    logic            rnd_mode = 1'b0;
    logic            ov_clr = 1'b0;
    logic            out_valid;
    logic [XLEN-1:0] acc_out;
    logic            ov_out;
    logic            ov_sticky;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [XLEN-1:0] res;
        logic            ov;
        string           tag;
    } exp_t;

    exp_t            sb[$];
    logic [XLEN-1:0] last_res = '0;

    always #2 clk = ~clk;

    simd_msw_mac #(.XLEN(XLEN)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .acc_in    (acc_in),
        .word_src  (word_src),
        .half_src  (half_src),
        .use_top   (use_top),
        .dbl_mode  (dbl_mode),
        .rnd_mode  (rnd_mode),
        .ov_clr    (ov_clr),
        .out_valid (out_valid),
        .acc_out   (acc_out),
        .ov_out    (ov_out),
        .ov_sticky (ov_sticky)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic reference: scaled product with optional rounding, then clamp.
    function automatic logic [32:0] lane_ref(input logic [31:0] a, input logic [31:0] w,
                                             input logic [15:0] h, input logic dbl,
                                             input logic rnd);
        longint p, add, s;
        logic   ov;
        p  = longint'($signed(w)) * longint'($signed(h));
        ov = 1'b0;
        if (dbl && w == 32'h8000_0000 && h == 16'h8000) begin
            add = 64'sd2147483647;
            ov  = 1'b1;
        end else if (dbl) begin
            add = (p + (rnd ? 64'sd16384 : 64'sd0)) >>> 15;
        end else begin
            add = (p + (rnd ? 64'sd32768 : 64'sd0)) >>> 16;
        end
        s = longint'($signed(a)) + add;
        if (s > 64'sd2147483647) begin
            s  = 64'sd2147483647;
            ov = 1'b1;
        end else if (s < -64'sd2147483648) begin
            s  = -64'sd2147483648;
            ov = 1'b1;
        end
        return {ov, s[31:0]};
    endfunction

    task automatic issue(input logic [XLEN-1:0] a, input logic [XLEN-1:0] w,
                         input logic [XLEN-1:0] h, input logic top, input logic dbl,
                         input logic rnd, input string tag);
        exp_t e;
        e.ov  = 1'b0;
        e.tag = tag;
        for (int ln = 0; ln < LANES; ln++) begin
            logic [32:0] r;
            logic [15:0] hh;
            hh = top ? h[ln*32+16 +: 16] : h[ln*32 +: 16];
            r  = lane_ref(a[ln*32 +: 32], w[ln*32 +: 32], hh, dbl, rnd);
            e.res[ln*32 +: 32] = r[31:0];
            e.ov = e.ov | r[32];
        end
        sb.push_back(e);
        acc_in   = a;
        word_src = w;
        half_src = h;
        use_top  = top;
        dbl_mode = dbl;
        rnd_mode = rnd;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare every produced result with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9 actual=unexpected result expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " value"}, acc_out, e.res);
                check({e.tag, " ov"}, {{(XLEN-1){1'b0}}, ov_out}, {{(XLEN-1){1'b0}}, e.ov});
                last_res = e.res;
            end
        end
    end

    function automatic logic [31:0] pick_word();
        case ($urandom_range(0, 5))
            0:       return 32'h8000_0000;
            1:       return 32'h7FFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    function automatic logic [15:0] pick_half();
        case ($urandom_range(0, 5))
            0:       return 16'h8000;
            1:       return 16'h7FFF;
            default: return 16'($urandom());
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 out_valid", {{(XLEN-1){1'b0}}, out_valid}, '0);
        check("R11 acc_out", acc_out, '0);
        check("R11 ov_out", {{(XLEN-1){1'b0}}, ov_out}, '0);
        check("R11 ov_sticky", {{(XLEN-1){1'b0}}, ov_sticky}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: bottom and top half select, distinct per lane
        issue(64'h0000_0010_0000_0005, 64'h0001_0000_0002_0000, 64'h0009_0007_0005_0003,
              1'b0, 1'b0, 1'b0, "R1 bottom");
        issue(64'h0000_0010_0000_0005, 64'h0001_0000_0002_0000, 64'h0009_0007_0005_0003,
              1'b1, 1'b0, 1'b0, "R1 top");
        // R2 / R3: truncation versus rounding at bit 15 (product 0x18000 and -0x18000)
        issue(64'h0, 64'hFFFF_FFFD_0000_0003, 64'h0000_8000_0000_8000,
              1'b0, 1'b0, 1'b0, "R2 trunc");
        issue(64'h0, 64'h0000_0003_0000_0003, 64'h0000_4000_0000_4000,
              1'b0, 1'b0, 1'b0, "R2 plain");
        issue(64'h0, 64'hFFFF_FFFD_0000_0003, 64'h0000_8000_0000_8000,
              1'b0, 1'b0, 1'b1, "R3 round");
        // R4 / R5: doubled forms, rounding at bit 14
        issue(64'h0000_0100_0000_0000, 64'h4000_0000_0000_6000, 64'h0000_4000_0000_0001,
              1'b0, 1'b1, 1'b0, "R4 doubled");
        issue(64'h0000_0100_0000_0000, 64'h4000_0000_0000_6000, 64'h0000_4000_0000_0001,
              1'b0, 1'b1, 1'b1, "R5 doubled round");
        // R6: forced addend; lane0 saturates twice, lane1 forced only
        issue(64'hFFFF_FFFB_0000_0010, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_8000,
              1'b1, 1'b1, 1'b0, "R6 corner top");
        issue(64'h0000_0000_7FFF_FFFF, 64'h0000_0001_8000_0000, 64'h0000_0001_0000_8000,
              1'b0, 1'b1, 1'b1, "R6 corner lane0 only");
        issue(64'h0, 64'h8000_0000_8000_0000, 64'h0000_8000_0000_8000,
              1'b0, 1'b0, 1'b0, "R6 no corner when plain");
        // R7: positive and negative clamps
        issue(64'h8000_0010_7FFF_FFF0, 64'h8000_0000_7FFF_FFFF, 64'h0000_7FFF_0000_7FFF,
              1'b0, 1'b0, 1'b0, "R7 clamp both");
        issue(64'h7FFF_0000_8000_0000, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001,
              1'b0, 1'b0, 1'b0, "R7 in range");
        drain();

        // R9: held value after the pipeline empties
        check("R9 hold", acc_out, last_res);
        check("R9 idle ov", {{(XLEN-1){1'b0}}, ov_out}, '0);

        // R10: sticky set by earlier overflow, then cleared
        check("R10 sticky set", {{(XLEN-1){1'b0}}, ov_sticky}, 1);
        issue(64'h0, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001,
              1'b0, 1'b0, 1'b0, "R10 clean op");
        drain();
        check("R10 sticky held", {{(XLEN-1){1'b0}}, ov_sticky}, 1);
        ov_clr = 1'b1;
        @(negedge clk);
        ov_clr = 1'b0;
        @(negedge clk);
        check("R10 sticky cleared", {{(XLEN-1){1'b0}}, ov_sticky}, 0);
        // R10: clear in the same cycle that an overflow reaches the flag
        issue(64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001,
              1'b0, 1'b0, 1'b0, "R10 ov op");
        ov_clr = 1'b1;
        @(negedge clk);
        ov_clr = 1'b0;
        drain();
        check("R10 clear loses to event", {{(XLEN-1){1'b0}}, ov_sticky}, 1);

        // R8: random back-to-back traffic across all modes and lanes
        for (int n = 0; n < 400; n++) begin
            logic [XLEN-1:0] a, w, h;
            for (int ln = 0; ln < LANES; ln++) begin
                a[ln*32 +: 32] = ($urandom_range(0, 3) == 0) ? 32'h7FFF_FF00 : $urandom();
                w[ln*32 +: 32] = pick_word();
                h[ln*32 +: 32] = {pick_half(), pick_half()};
            end
            issue(a, w, h, 1'($urandom()), 1'($urandom()), 1'($urandom()), "R8 random");
        end
        drain();
        check("R9 queue empty", 64'(sb.size()), '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule